// File: doc/BRIEF.md
# Zero-Operand Stack Execution Unit

This block runs a narrow stream of stack-machine instructions against a synchronous data memory. It keeps a small operand stack in internal registers. Two instructions move words between that stack and memory: one loads a word from a given address onto the top, and the other stores the top word to a given address and removes it. The two arithmetic instructions name no operand at all. Each one takes the two uppermost entries and leaves a single result in their place, so the stack serves as both source and destination.

Instructions arrive on a valid/ready port that carries a 2-bit opcode and an address. A load must wait one cycle for the memory read, so the port drops ready for that cycle and the busy flag goes high. Any instruction that would overrun the stack or read past its bottom sets a fault flag instead of running. The fault flag stays set until reset. Later instructions still execute normally.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset, instrReady is 1, busy is 0, fault is 0, and neither memRdEn nor memWrEn is asserted.
- R2: Opcode 00 (load) asserts memRdEn with memAddr equal to instrAddr in the cycle the instruction is accepted. The word the memory returns one cycle later becomes the new top. During that second cycle instrReady is 0 and busy is 1, and the unit is ready again on the cycle after.
- R3: Opcode 01 (store) asserts memWrEn with memAddr equal to instrAddr and memWdata equal to the top entry in the accept cycle, then removes that entry. The instruction completes in one cycle.
- R4: Opcode 10 (add) replaces the two top entries with their sum modulo 2^WIDTH. The depth drops by one and the instruction completes in one cycle.
- R5: Opcode 11 (subtract) replaces the two top entries with the entry below the top minus the top, modulo 2^WIDTH.
- R6: The sequence load A, load B, add, store C leaves memory[C] equal to memory[A] + memory[B] and returns the stack to the depth it had before.
- R7: Stores return entries in reverse order of their loads (last in, first out).
- R8: A load when the stack already holds DEPTH entries raises fault, issues no memory read, and leaves the stack unchanged.
- R9: A store on an empty stack raises fault and issues no memory write.
- R10: An add or subtract with fewer than two entries raises fault and leaves the stack unchanged.
- R11: Once raised, fault stays high until reset, and later valid instructions still execute normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | An instruction is offered |
| instrReady | output | 1 | The unit can accept an instruction this cycle |
| instrOp | input | 2 | Opcode: 00 load, 01 store, 10 add, 11 subtract |
| instrAddr | input | ADDR_W | Memory address used by load and store |
| memAddr | output | ADDR_W | Data memory address |
| memRdEn | output | 1 | Memory read strobe; data appears on memRdata one cycle later |
| memRdata | input | WIDTH | Word read from memory |
| memWrEn | output | 1 | Memory write strobe |
| memWdata | output | WIDTH | Word to write |
| busy | output | 1 | A load is waiting for its memory data |
| fault | output | 1 | Sticky overflow or underflow flag |

## Verification
The bench builds the unit with DEPTH=4, WIDTH=32 and ADDR_W=8. The shallow stack lets a short run fill it completely, overflow it, and then drain it past empty, so every guard path in the controller is exercised. At the full 32-bit width, the wrap-around cases for add (all-ones plus two) and for a negative subtract result produce the exact modular values named in the requirements.

// File: rtl/stack_exec_pkg.sv
package stack_exec_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_ADD   = 2'b10,
    OP_SUB   = 2'b11
  } stackOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTop;   // write returned memory word above current top
    logic dropTop;   // remove top entry
    logic combine;   // fold two top entries into one
    logic subtract;  // combine uses next-minus-top instead of sum
  } stackCtrl_t;

endpackage

// File: rtl/stack_exec_ctrl.sv
module stack_exec_ctrl
  import stack_exec_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instrValid,
  input  logic [1:0]    instrOp,
  input  logic [CW-1:0] depthCount,
  output stackCtrl_t    ctrl,
  output logic          instrReady,
  output logic          busy,
  output logic          fault,
  output logic          memRdEn,
  output logic          memWrEn
);

  typedef enum logic {S_IDLE, S_FILL} state_e;

  state_e   state;
  stackOp_e opIn;
  logic     accept;
  logic     isFull, hasOne, hasTwo;
  logic     loadOk, storeOk, arithOk, badOp;

  assign opIn   = stackOp_e'(instrOp);
  assign accept = instrValid && (state == S_IDLE);
  assign isFull = (depthCount == CW'(DEPTH));
  assign hasOne = (depthCount != '0);
  assign hasTwo = (depthCount >= CW'(2));

  always_comb begin
    loadOk  = accept && (opIn == OP_LOAD) && !isFull;
    storeOk = accept && (opIn == OP_STORE) && hasOne;
    arithOk = accept && ((opIn == OP_ADD) || (opIn == OP_SUB)) && hasTwo;
    badOp   = accept && !(loadOk || storeOk || arithOk);
  end

  always_comb begin
    ctrl.loadTop  = (state == S_FILL);
    ctrl.dropTop  = storeOk;
    ctrl.combine  = arithOk;
    ctrl.subtract = (opIn == OP_SUB);
  end

  assign memRdEn    = loadOk;
  assign memWrEn    = storeOk;
  assign instrReady = (state == S_IDLE);
  assign busy       = (state == S_FILL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      fault <= 1'b0;
    end else begin
      state <= loadOk ? S_FILL : S_IDLE;
      fault <= fault | badOp;
    end
  end

endmodule

// File: rtl/stack_exec_dp.sv
module stack_exec_dp
  import stack_exec_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackCtrl_t       ctrl,
  input  logic [WIDTH-1:0] memRdata,
  output logic [CW-1:0]    depthCount,
  output logic [WIDTH-1:0] topWord
);

  logic [WIDTH-1:0] stkMem [DEPTH];
  logic [WIDTH-1:0] nextWord;
  logic [WIDTH-1:0] result;
  logic [CW-1:0]    topIdx, nextIdx;

  assign topIdx  = depthCount - CW'(1);
  assign nextIdx = depthCount - CW'(2);

  always_comb begin
    topWord  = '0;
    nextWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) == topIdx)  topWord  = stkMem[i];
      if (CW'(i) == nextIdx) nextWord = stkMem[i];
    end
  end

  assign result = ctrl.subtract ? (nextWord - topWord) : (nextWord + topWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stkMem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ctrl.loadTop && (depthCount == CW'(i)))
          stkMem[i] <= memRdata;
        else if (ctrl.combine && (nextIdx == CW'(i)))
          stkMem[i] <= result;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      depthCount <= '0;
    else if (ctrl.loadTop)
      depthCount <= depthCount + CW'(1);
    else if (ctrl.dropTop || ctrl.combine)
      depthCount <= depthCount - CW'(1);
  end

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
  import stack_exec_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  output logic              instrReady,
  input  logic [1:0]        instrOp,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [WIDTH-1:0]  memRdata,
  output logic              memWrEn,
  output logic [WIDTH-1:0]  memWdata,
  output logic              busy,
  output logic              fault
);

  localparam int CW = $clog2(DEPTH + 1);

  stackCtrl_t    ctrl;
  logic [CW-1:0] depthCount;

  stack_exec_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instrOp    (instrOp),
    .depthCount (depthCount),
    .ctrl       (ctrl),
    .instrReady (instrReady),
    .busy       (busy),
    .fault      (fault),
    .memRdEn    (memRdEn),
    .memWrEn    (memWrEn)
  );

  stack_exec_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .memRdata   (memRdata),
    .depthCount (depthCount),
    .topWord    (memWdata)
  );

  assign memAddr = instrAddr;

endmodule

// File: rtl/stack_exec_chk.sv
module stack_exec_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          instrValid,
  input logic          instrReady,
  input logic [1:0]    instrOp,
  input logic          memRdEn,
  input logic          memWrEn,
  input logic          busy,
  input logic          fault,
  input logic [CW-1:0] depthCount
);

  logic takeIt;
  assign takeIt = instrValid && instrReady;

  // R2
  load_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (busy && !instrReady));

  // R2
  fill_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R3
  store_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (takeIt && instrOp == 2'b01));

  // R3
  store_pops_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (depthCount == CW'($past(depthCount) - 1'b1)));

  // R4
  arith_shrink_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIt && instrOp[1] && depthCount >= CW'(2)) |=>
      (depthCount == CW'($past(depthCount) - 1'b1)));

  // R8
  over_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIt && instrOp == 2'b00 && depthCount == CW'(DEPTH)) |-> !memRdEn);

  // R9
  under_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIt && instrOp == 2'b01 && depthCount == '0) |=> (fault && $stable(depthCount)));

  // R10
  arith_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIt && instrOp[1] && depthCount < CW'(2)) |=> (fault && $stable(depthCount)));

  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);

endmodule

bind stack_exec_unit stack_exec_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .instrReady (instrReady),
  .instrOp    (instrOp),
  .memRdEn    (memRdEn),
  .memWrEn    (memWrEn),
  .busy       (busy),
  .fault      (fault),
  .depthCount (depthCount)
);

// File: tb/stack_exec_unit_bench.sv
module stack_exec_unit_bench;

  localparam int WIDTH  = 32;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              instrValid = 1'b0;
  logic              instrReady;
  logic [1:0]        instrOp = 2'b00;
  logic [ADDR_W-1:0] instrAddr = '0;
  logic [ADDR_W-1:0] memAddr;
  logic              memRdEn;
  logic [WIDTH-1:0]  memRdata;
  logic              memWrEn;
  logic [WIDTH-1:0]  memWdata;
  logic              busy;
  logic              fault;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [WIDTH-1:0]  mem [1 << ADDR_W];
  logic [WIDTH-1:0]  refStk [$];
  logic [ADDR_W-1:0] expAddrQ [$];
  logic [WIDTH-1:0]  expDataQ [$];
  string             expTagQ [$];
  logic              expFault = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  stack_exec_unit #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_stack_exec_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrReady(instrReady),
    .instrOp(instrOp), .instrAddr(instrAddr), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdata(memRdata), .memWrEn(memWrEn), .memWdata(memWdata),
    .busy(busy), .fault(fault)
  );

  // synchronous memory model
  always @(posedge clk) begin
    if (memRdEn) memRdata <= mem[memAddr];
    if (memWrEn) mem[memAddr] <= memWdata;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compares every memory write against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (expAddrQ.size() == 0) begin
        check(1'b0, "R9", "write with nothing expected", {24'h0, memAddr}, '0);
      end else begin
        string t;
        logic [ADDR_W-1:0] ea;
        logic [WIDTH-1:0] ed;
        t  = expTagQ.pop_front();
        ea = expAddrQ.pop_front();
        ed = expDataQ.pop_front();
        check(memAddr == ea, t, "write address", {24'h0, memAddr}, {24'h0, ea});
        check(memWdata == ed, t, "write data", memWdata, ed);
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    instrValid = 1'b0;
    refStk.delete();
    expFault = 1'b0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
  endtask

  // driver: updates the reference stack and queues expected writes
  task automatic issue(input logic [1:0] op, input logic [ADDR_W-1:0] addr, input string tag);
    logic expRd;
    logic [WIDTH-1:0] a, b;
    @(posedge clk); #2;
    while (!instrReady) begin @(posedge clk); #2; end
    expRd = 1'b0;
    case (op)
      2'b00: if (refStk.size() == DEPTH) expFault = 1'b1;
             else begin expRd = 1'b1; refStk.push_back(mem[addr]); end
      2'b01: if (refStk.size() == 0) expFault = 1'b1;
             else begin
               expTagQ.push_back(tag); expAddrQ.push_back(addr);
               expDataQ.push_back(refStk.pop_back());
             end
      default: if (refStk.size() < 2) expFault = 1'b1;
               else begin
                 b = refStk.pop_back(); a = refStk.pop_back();
                 refStk.push_back(op == 2'b10 ? a + b : a - b);
               end
    endcase
    instrValid = 1'b1; instrOp = op; instrAddr = addr;
    #1;
    check(memRdEn == expRd, tag, "read strobe", {31'h0, memRdEn}, {31'h0, expRd});
    if (expRd) check(memAddr == addr, tag, "read address", {24'h0, memAddr}, {24'h0, addr});
    @(posedge clk); #2;
    instrValid = 1'b0;
    check(fault == expFault, tag, "fault flag", {31'h0, fault}, {31'h0, expFault});
    if (expRd) begin
      check(busy && !instrReady, "R2", "busy during fill", {31'h0, busy}, 1);
      @(posedge clk); #2;
      check(!busy && instrReady, "R2", "ready after fill", {31'h0, instrReady}, 1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;
    mem[10] = 32'd100;  mem[11] = 32'd23;
    mem[12] = 32'hFFFF_FFFF; mem[13] = 32'd2;
    mem[14] = 32'd50;   mem[15] = 32'd8;

    doReset();
    @(negedge clk);
    check(instrReady && !busy && !fault && !memRdEn && !memWrEn, "R1", "idle after reset",
          {27'h0, instrReady, busy, fault, memRdEn, memWrEn}, 32'h10);

    // R6 with R4: load, load, add, store
    issue(2'b00, 8'd10, "R6"); issue(2'b00, 8'd11, "R6");
    issue(2'b10, 8'd0, "R4");  issue(2'b01, 8'd20, "R6");
    @(posedge clk); #2;
    check(mem[20] == 32'd123, "R6", "memory result", mem[20], 32'd123);

    // R4 wrap
    issue(2'b00, 8'd12, "R4"); issue(2'b00, 8'd13, "R4");
    issue(2'b10, 8'd0, "R4");  issue(2'b01, 8'd21, "R4");

    // R5 order and wrap
    issue(2'b00, 8'd14, "R5"); issue(2'b00, 8'd15, "R5");
    issue(2'b11, 8'd0, "R5");  issue(2'b01, 8'd22, "R5");
    issue(2'b00, 8'd15, "R5"); issue(2'b00, 8'd14, "R5");
    issue(2'b11, 8'd0, "R5");  issue(2'b01, 8'd23, "R5");

    // R7 last in, first out
    issue(2'b00, 8'd10, "R7"); issue(2'b00, 8'd11, "R7"); issue(2'b00, 8'd12, "R7");
    issue(2'b01, 8'd30, "R7"); issue(2'b01, 8'd31, "R7"); issue(2'b01, 8'd32, "R7");

    // R9 underflow, then R11 sticky yet still working
    issue(2'b01, 8'd40, "R9");
    issue(2'b00, 8'd10, "R11"); issue(2'b01, 8'd41, "R11");

    // R10 arithmetic with one entry
    doReset();
    issue(2'b00, 8'd11, "R10"); issue(2'b10, 8'd0, "R10");
    issue(2'b11, 8'd0, "R10");  issue(2'b01, 8'd42, "R10");

    // R8 overflow, then drain past empty
    doReset();
    for (int i = 0; i < DEPTH; i++) issue(2'b00, ADDR_W'(10 + i), "R8");
    issue(2'b00, 8'd14, "R8");
    for (int i = 0; i < DEPTH; i++) issue(2'b01, ADDR_W'(50 + i), "R8");
    issue(2'b01, 8'd60, "R9");

    repeat (3) @(posedge clk); #2;
    check(expAddrQ.size() == 0, "R3", "all expected writes seen", expAddrQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule